// File: doc/BRIEF.md
# Domain-Based Memory Protection Unit

This block sits beside a processor's load/store and fetch path. It checks every access against a small set of domain registers. Each domain covers an address range from a low bound to a high bound, and both bounds belong to the range. Each domain also holds an enable flag, separate read, write and execute permission bits, and a flag that restricts the domain to supervisor mode.

The check is combinational. In the cycle a request is presented, the block either grants it or reports one of two fault codes to the trap controller:

- An address that no enabled domain contains is reported as an out-of-range reference.
- An address that some enabled domain contains, but that no containing domain permits for this access type and mode, is reported as a permission fault.

When a request faults, its address is captured at the clock edge. A trap handler can then read it from `fault_addr_o`.

Software programs the domain registers through a simple write port. Each write names the domain, the field and the data. The port accepts a write only while the supervisor mode input is high.

Top module: `domain_guard`

## Requirements
- R1: After reset every domain is disabled and `fault_addr_o` is 0, so any request is refused with fault code 1.
- R2: A request whose address lies within [low, high] of an enabled domain that permits the access in the current mode gets `grant_o`=1 and `fault_o`=0 in the same cycle. Both bounds are inclusive.
- R3: A request whose address lies outside every enabled domain gets `grant_o`=0 and `fault_o`=1 (out of range).
- R4: Access kinds are encoded as load=0, store=1, fetch=2 and 3=reserved; the reserved kind is never permitted. A load needs the read bit, a store the write bit and a fetch the execute bit. An in-bounds request that lacks the needed bit gets `fault_o`=2 (permission).
- R5: A domain whose supervisor-only bit is set permits nothing while `priv_i`=0. An in-bounds user access to it reports `fault_o`=2. The same access with `priv_i`=1 is governed by the permission bits alone.
- R6: When several domains contain the address, the request is granted if any one of them permits it.
- R7: A domain whose enable bit is 0 never contains any address.
- R8: A configuration write presented with `priv_i`=0 changes nothing. A write presented with `priv_i`=1 takes effect from the next clock edge on.
  - Field codes are 0=low bound, 1=high bound, 2=attributes and 3=no effect.
  - The attribute bits are [0] enable, [1] read, [2] write, [3] execute and [4] supervisor-only.
- R9: On a clock edge where `req_valid_i`=1 and `fault_o`≠0, `fault_addr_o` takes `req_addr_i`. In every other cycle it keeps its value.
- R10: With `req_valid_i`=0 the outputs are `grant_o`=0 and `fault_o`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| priv_i | input | 1 | Current mode, 1 = supervisor |
| req_valid_i | input | 1 | Access request present |
| req_addr_i | input | ADDR_W | Access address |
| req_kind_i | input | 2 | Access kind: 0 load, 1 store, 2 fetch, 3 reserved |
| cfg_we_i | input | 1 | Domain register write strobe |
| cfg_idx_i | input | IDX_W | Domain selected for write |
| cfg_field_i | input | 2 | Field selected: 0 low, 1 high, 2 attributes |
| cfg_wdata_i | input | ADDR_W | Write data |
| grant_o | output | 1 | Access allowed |
| fault_o | output | 2 | 0 none, 1 out of range, 2 permission |
| fault_addr_o | output | ADDR_W | Address of the most recent faulting request |

## Verification
A domain register that holds a wrong bound or attribute shows up at once, in the same cycle, as a wrong grant or fault code for addresses at that domain's edges. The stimulus therefore probes the first and last byte of each range, as well as the byte just beyond it.

A configuration write that lands when it should be refused shows up one edge later, as a grant where a fault was expected. The captured fault address is compared one edge after each request, so a missed or spurious capture shows up within one cycle.

// File: rtl/dg_pkg.sv
package dg_pkg;
   typedef enum logic [1:0] {
      ACC_LOAD  = 2'd0,
      ACC_STORE = 2'd1,
      ACC_FETCH = 2'd2,
      ACC_RSVD  = 2'd3
   } acc_kind_e;

   typedef enum logic [1:0] {
      FLT_NONE    = 2'd0,
      FLT_OUTSIDE = 2'd1,
      FLT_DENIED  = 2'd2
   } fault_e;

   typedef enum logic [1:0] {
      FLD_LOW  = 2'd0,
      FLD_HIGH = 2'd1,
      FLD_ATTR = 2'd2,
      FLD_NONE = 2'd3
   } cfg_field_e;

   localparam int ATTR_W     = 5;
   localparam int ATTR_EN    = 0;
   localparam int ATTR_RD    = 1;
   localparam int ATTR_WR    = 2;
   localparam int ATTR_EX    = 3;
   localparam int ATTR_SUPER = 4;
endpackage

// File: rtl/dg_domain_slot.sv
module dg_domain_slot
   import dg_pkg::*;
#(
   parameter int ADDR_W = 32,
   parameter int IDX_W  = 2,
   parameter int SLOT   = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_we,
   input  logic              cfg_priv,
   input  logic [IDX_W-1:0]  cfg_idx,
   input  logic [1:0]        cfg_field,
   input  logic [ADDR_W-1:0] cfg_wdata,
   input  logic [ADDR_W-1:0] acc_addr,
   input  logic [1:0]        acc_kind,
   input  logic              acc_priv,
   output logic              contains,
   output logic              permits
);
   logic [ADDR_W-1:0] lo_q, hi_q;
   logic [ATTR_W-1:0] attr_q;
   logic              sel;
   logic              kind_ok;

   assign sel = cfg_we && cfg_priv && (cfg_idx == IDX_W'(SLOT));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lo_q   <= '0;
         hi_q   <= '0;
         attr_q <= '0;
      end else if (sel) begin
         case (cfg_field_e'(cfg_field))
            FLD_LOW:  lo_q   <= cfg_wdata;
            FLD_HIGH: hi_q   <= cfg_wdata;
            FLD_ATTR: attr_q <= cfg_wdata[ATTR_W-1:0];
            default:  ;
         endcase
      end
   end

   always_comb begin
      case (acc_kind_e'(acc_kind))
         ACC_LOAD:  kind_ok = attr_q[ATTR_RD];
         ACC_STORE: kind_ok = attr_q[ATTR_WR];
         ACC_FETCH: kind_ok = attr_q[ATTR_EX];
         default:   kind_ok = 1'b0;
      endcase
   end

   assign contains = attr_q[ATTR_EN] && (acc_addr >= lo_q) && (acc_addr <= hi_q);
   assign permits  = contains && kind_ok && (acc_priv || !attr_q[ATTR_SUPER]);

   assert_user_cfg_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_we && !cfg_priv) |=> ($stable(lo_q) && $stable(hi_q) && $stable(attr_q)));

   assert_disabled_never_hits_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !attr_q[ATTR_EN] |-> !contains);
endmodule

// File: rtl/dg_verdict.sv
module dg_verdict
   import dg_pkg::*;
#(
   parameter int NUM_DOM = 4
) (
   input  logic               req_valid,
   input  logic [NUM_DOM-1:0] contains,
   input  logic [NUM_DOM-1:0] permits,
   output logic               grant,
   output logic [1:0]         fault
);
   always_comb begin
      grant = 1'b0;
      fault = FLT_NONE;
      if (req_valid) begin
         if (|permits)       grant = 1'b1;
         else if (|contains) fault = FLT_DENIED;
         else                fault = FLT_OUTSIDE;
      end
   end
endmodule

// File: rtl/domain_guard.sv
module domain_guard
   import dg_pkg::*;
#(
   parameter int ADDR_W  = 32,
   parameter int NUM_DOM = 4,
   localparam int IDX_W  = (NUM_DOM > 1) ? $clog2(NUM_DOM) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              priv_i,
   input  logic              req_valid_i,
   input  logic [ADDR_W-1:0] req_addr_i,
   input  logic [1:0]        req_kind_i,
   input  logic              cfg_we_i,
   input  logic [IDX_W-1:0]  cfg_idx_i,
   input  logic [1:0]        cfg_field_i,
   input  logic [ADDR_W-1:0] cfg_wdata_i,
   output logic              grant_o,
   output logic [1:0]        fault_o,
   output logic [ADDR_W-1:0] fault_addr_o
);
   if (ADDR_W < ATTR_W) begin : g_bad_width
      $error("domain_guard: ADDR_W must be at least ATTR_W");
   end
   if (NUM_DOM < 1) begin : g_bad_count
      $error("domain_guard: NUM_DOM must be at least 1");
   end

   logic [NUM_DOM-1:0] dom_contains, dom_permits;

   for (genvar d = 0; d < NUM_DOM; d++) begin : g_slot
      dg_domain_slot #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .SLOT(d)) slot_i (
         .clk       (clk),
         .rst_n     (rst_n),
         .cfg_we    (cfg_we_i),
         .cfg_priv  (priv_i),
         .cfg_idx   (cfg_idx_i),
         .cfg_field (cfg_field_i),
         .cfg_wdata (cfg_wdata_i),
         .acc_addr  (req_addr_i),
         .acc_kind  (req_kind_i),
         .acc_priv  (priv_i),
         .contains  (dom_contains[d]),
         .permits   (dom_permits[d])
      );
   end

   dg_verdict #(.NUM_DOM(NUM_DOM)) verdict_i (
      .req_valid (req_valid_i),
      .contains  (dom_contains),
      .permits   (dom_permits),
      .grant     (grant_o),
      .fault     (fault_o)
   );

   logic capture;
   assign capture = req_valid_i && (fault_o != FLT_NONE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       fault_addr_o <= '0;
      else if (capture) fault_addr_o <= req_addr_i;
   end

   assert_grant_backed_R6: assert property (@(posedge clk) disable iff (!rst_n)
      grant_o |-> (|dom_permits));
   assert_denied_in_bounds_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (fault_o == FLT_DENIED) |-> (|dom_contains));
   assert_outside_no_hit_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (fault_o == FLT_OUTSIDE) |-> !(|dom_contains));
   assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid_i |-> (!grant_o && fault_o == FLT_NONE));
   assert_capture_addr_R9: assert property (@(posedge clk) disable iff (!rst_n)
      capture |=> (fault_addr_o == $past(req_addr_i)));
   assert_hold_addr_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !capture |=> $stable(fault_addr_o));
endmodule

// File: tb/domain_guard_tb.sv
module domain_guard_tb_top;
   localparam int CLK_PERIOD = 10;

   typedef struct packed {
      logic [31:0] addr;
      logic [1:0]  kind;
      logic        priv;
      logic        grant;
      logic [1:0]  fault;
   } vec_t;

   localparam int NVEC = 14;
   localparam vec_t VECS [NVEC] = '{
      '{32'h0000_1000, 2'd0, 1'b0, 1'b1, 2'd0},
      '{32'h0000_1FFF, 2'd2, 1'b0, 1'b1, 2'd0},
      '{32'h0000_0FFF, 2'd0, 1'b0, 1'b0, 2'd1},
      '{32'h0000_3000, 2'd0, 1'b0, 1'b0, 2'd1},
      '{32'h0000_1000, 2'd1, 1'b0, 1'b0, 2'd2},
      '{32'h0000_1900, 2'd1, 1'b0, 1'b1, 2'd0},
      '{32'h0000_2100, 2'd2, 1'b0, 1'b0, 2'd2},
      '{32'h0000_2FFF, 2'd1, 1'b0, 1'b1, 2'd0},
      '{32'h0000_8000, 2'd0, 1'b0, 1'b0, 2'd2},
      '{32'h0000_8000, 2'd0, 1'b1, 1'b1, 2'd0},
      '{32'h0000_80FF, 2'd2, 1'b1, 1'b1, 2'd0},
      '{32'h0000_8100, 2'd0, 1'b1, 1'b0, 2'd1},
      '{32'h0000_1000, 2'd3, 1'b1, 1'b0, 2'd2},
      '{32'hFFFF_FFFF, 2'd0, 1'b1, 1'b0, 2'd1}
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        priv = 1'b0;
   logic        req_valid = 1'b0;
   logic [31:0] req_addr = '0;
   logic [1:0]  req_kind = '0;
   logic        cfg_we = 1'b0;
   logic [1:0]  cfg_idx = '0;
   logic [1:0]  cfg_field = '0;
   logic [31:0] cfg_wdata = '0;
   logic        grant;
   logic [1:0]  fault;
   logic [31:0] fault_addr;

   int tests = 0;
   int fails = 0;
   logic [31:0] last_fault_addr = '0;

   always #(CLK_PERIOD/2) clk = ~clk;

   domain_guard dut_i (
      .clk(clk), .rst_n(rst_n), .priv_i(priv),
      .req_valid_i(req_valid), .req_addr_i(req_addr), .req_kind_i(req_kind),
      .cfg_we_i(cfg_we), .cfg_idx_i(cfg_idx), .cfg_field_i(cfg_field),
      .cfg_wdata_i(cfg_wdata),
      .grant_o(grant), .fault_o(fault), .fault_addr_o(fault_addr)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      tests++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic cfg_write(input logic p, input int idx, input int fld, input logic [31:0] d);
      @(negedge clk);
      priv = p; cfg_we = 1'b1; cfg_idx = 2'(idx); cfg_field = 2'(fld); cfg_wdata = d;
      @(negedge clk);
      cfg_we = 1'b0;
   endtask

   task automatic set_dom(input int idx, input logic [31:0] lo, input logic [31:0] hi,
                          input logic [31:0] attr);
      cfg_write(1'b1, idx, 0, lo);
      cfg_write(1'b1, idx, 1, hi);
      cfg_write(1'b1, idx, 2, attr);
   endtask

   // Drive one request at a falling edge, check the combinational verdict,
   // then check the captured address after the following rising edge.
   task automatic probe(input string req, input logic [31:0] a, input logic [1:0] k,
                        input logic p, input logic eg, input logic [1:0] ef);
      @(negedge clk);
      priv = p; req_valid = 1'b1; req_addr = a; req_kind = k;
      #1;
      check({req, " grant"}, 32'(grant), 32'(eg));
      check({req, " fault"}, 32'(fault), 32'(ef));
      if (ef != 2'd0) last_fault_addr = a;
      @(negedge clk);
      req_valid = 1'b0;
      #1;
      check("R9 fault_addr", fault_addr, last_fault_addr);
   endtask

   initial begin
      repeat (10000) @(posedge clk);
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      #1;
      // R1: reset state
      check("R1 fault_addr after reset", fault_addr, 32'h0);
      check("R10 idle grant", 32'(grant), 32'h0);
      check("R10 idle fault", 32'(fault), 32'h0);
      probe("R1 empty table", 32'h0000_1000, 2'd0, 1'b1, 1'b0, 2'd1);

      // D0 read+exec, D1 read+write, D2 all + supervisor-only
      set_dom(0, 32'h0000_1000, 32'h0000_1FFF, 32'h0B);
      set_dom(1, 32'h0000_2000, 32'h0000_2FFF, 32'h07);
      set_dom(2, 32'h0000_8000, 32'h0000_80FF, 32'h1F);

      // R8: user-mode writes to D3 are ignored
      cfg_write(1'b0, 3, 0, 32'h0000_1800);
      cfg_write(1'b0, 3, 1, 32'h0000_27FF);
      cfg_write(1'b0, 3, 2, 32'h05);
      probe("R8 user cfg ignored", 32'h0000_1900, 2'd1, 1'b0, 1'b0, 2'd2);

      // R8: field code 3 has no effect
      cfg_write(1'b1, 0, 3, 32'h0000_0000);
      probe("R8 field3 no effect", 32'h0000_0FFF, 2'd0, 1'b0, 1'b0, 2'd1);

      // D3 write-only overlap
      set_dom(3, 32'h0000_1800, 32'h0000_27FF, 32'h05);

      // Table-driven: R2 bounds, R3 outside, R4 kinds, R5 supervisor, R6 overlap
      for (int i = 0; i < NVEC; i++) begin
         probe($sformatf("R2-6 vec%0d", i), VECS[i].addr, VECS[i].kind,
               VECS[i].priv, VECS[i].grant, VECS[i].fault);
      end

      // R7: disable D2, its range becomes out of range
      cfg_write(1'b1, 2, 2, 32'h1E);
      probe("R7 disabled domain", 32'h0000_8000, 2'd0, 1'b1, 1'b0, 2'd1);

      // R10: no request gives no verdict and keeps fault address
      @(negedge clk);
      req_valid = 1'b0; req_addr = 32'h0000_0004;
      #1;
      check("R10 no req grant", 32'(grant), 32'h0);
      check("R10 no req fault", 32'(fault), 32'h0);
      @(negedge clk);
      check("R9 held when idle", fault_addr, last_fault_addr);

      // R9: granted access does not move the captured address
      probe("R9 grant keeps addr", 32'h0000_2000, 2'd0, 1'b0, 1'b1, 2'd0);

      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule